// File: doc/BRIEF.md
# Switchable Internal I/O Interconnect

This block sits between an embedded programmable fabric and the host side of the chip. Its 30 external pads pass straight through to the fabric. It also steers the fabric's 114 internal I/O positions to one of two host interfaces. In probe mode those positions connect to a 128-bit logic-analyzer port. The 14 analyzer bits left over are fed from monitor points inside the fabric. In bus mode the same positions carry the signals of a host request/acknowledge bus at fixed places, and a block of ten positions is left unconnected.

A single asynchronous mode pin chooses the interface. The block passes it through a two-stage synchronizer before it steers any multiplexer. The interface that is not selected sees only zeros, so fabric activity never reaches it. The bus handshake is carried through unchanged and without delay. A request stays asserted until the fabric raises the acknowledge, so back-pressure comes entirely from the soft bus slave built in the fabric. The block adds no buffering and no valid/ready stage of its own.

Top module: `fabric_io_switch`

## Requirements
- R1: In both modes `fab_ext_in` equals `ext_pad_in`, `ext_pad_out` equals `fab_ext_out`, and `ext_pad_oe` equals `fab_ext_oe`, all without a register.
- R2: A change on `mode_sel` reaches the multiplexers after exactly two rising clock edges. Value 0 selects probe mode and value 1 selects bus mode. Between the change and the second edge, the outputs still follow the old mode.
- R3: In probe mode `fab_int_in[i]` equals `la_in[i]` for every internal position i from 0 to 113.
- R4: In probe mode `la_out[i]` equals `fab_int_out[i]` for i from 0 to 113, and `la_out[114+j]` equals `fab_mon[j]` for j from 0 to 13.
- R5: In bus mode the host request bits drive fixed internal positions: `bus_cyc` drives 0, `bus_stb` drives 1 and `bus_we` drives 2. `bus_sel[k]` drives 3+k, `bus_adr[k]` drives 7+k and `bus_wdat[k]` drives 39+k.
- R6: In bus mode `bus_ack` is taken from internal position 71. `bus_rdat[k]` is taken from position 72+k for k below 20, and from position 82+k for k from 20 to 31.
- R7: In bus mode internal positions 92 to 101 (fabric positions 122 to 131, where fabric position = internal + 30) have `fab_int_in` held at 0, and their `fab_int_out` values have no effect on any output.
- R8: The path that is not selected outputs zeros. In bus mode all 128 bits of `la_out` are 0, and so is `fab_int_in` at the response positions 71 and 72 to 91 and 102 to 113. In probe mode `bus_ack` and `bus_rdat` are 0.
- R9: While `rst_n` is low the block is in probe mode, whatever the level on `mode_sel`. After reset is released, the pin takes two edges to take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Asynchronous mode pin: 0 selects probe, 1 selects bus |
| ext_pad_in | input | 30 | Values arriving from the external pads |
| ext_pad_out | output | 30 | Values driven onto the external pads |
| ext_pad_oe | output | 30 | Output enables for the external pads |
| fab_ext_in | output | 30 | Fabric side of the external pad inputs |
| fab_ext_out | input | 30 | Fabric drive for the external pads |
| fab_ext_oe | input | 30 | Fabric output enables for the external pads |
| fab_int_in | output | 114 | Values delivered to the internal fabric positions |
| fab_int_out | input | 114 | Values driven by the internal fabric positions |
| fab_mon | input | 14 | Fabric-internal monitor points |
| la_in | input | 114 | Analyzer bits driven by the host toward the fabric |
| la_out | output | 128 | Analyzer bits read by the host |
| bus_cyc | input | 1 | Host bus cycle-active qualifier |
| bus_stb | input | 1 | Host bus request strobe, held until acknowledged |
| bus_we | input | 1 | Host bus write enable |
| bus_sel | input | 4 | Host bus byte selects |
| bus_adr | input | 32 | Host bus address |
| bus_wdat | input | 32 | Host bus write data |
| bus_ack | output | 1 | Acknowledge from the fabric's soft slave |
| bus_rdat | output | 32 | Read data from the fabric's soft slave |

## Verification
The only state in the block is the two-flop mode pipeline. If it is wrong, every multiplexer flips as a group. A probe snapshot then reads as zeros at `la_out`, or bus fields appear at the wrong positions of `fab_int_in`, and this shows at the first comparison after the faulty edge. A lag that is off by one edge shows up in the cycle between the first and second edge after a `mode_sel` change, so the bench samples outputs in both of those half-periods. A wrong entry in the position map is combinational and is visible at once. It is caught by driving every analyzer and bus bit with independent values and by flipping only the unconnected block while watching the bus response.

// File: rtl/fio_pkg.sv
package fio_pkg;

  typedef enum logic {
    MODE_PROBE = 1'b0,
    MODE_BUS   = 1'b1
  } io_mode_e;

  localparam int EXT_W_D  = 30;
  localparam int INT_W_D  = 114;
  localparam int LA_W_D   = 128;
  localparam int ADDR_W_D = 32;
  localparam int DATA_W_D = 32;
  localparam int SEL_W_D  = 4;
  localparam int GAP_LO_D = 92;
  localparam int GAP_N_D  = 10;

endpackage

// File: rtl/fio_mode_sync.sv
module fio_mode_sync
  import fio_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mode_async,
  output io_mode_e mode
);

  logic meta_q;
  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      meta_q <= mode_async;
      held_q <= meta_q;
    end
  end

  assign mode = held_q ? MODE_BUS : MODE_PROBE;

  // R2: entering bus mode needs the pin high two edges earlier
  a_r2_rise_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_q) |-> $past(mode_async, 2));

  // R2: leaving bus mode needs the pin low two edges earlier
  a_r2_fall_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_q) |-> !$past(mode_async, 2));

endmodule

// File: rtl/fio_ext_pass.sv
module fio_ext_pass #(
  parameter int EXT_W = 30
) (
  input  logic [EXT_W-1:0] pad_in,
  output logic [EXT_W-1:0] pad_out,
  output logic [EXT_W-1:0] pad_oe,
  output logic [EXT_W-1:0] core_in,
  input  logic [EXT_W-1:0] core_out,
  input  logic [EXT_W-1:0] core_oe
);

  assign core_in = pad_in;
  assign pad_out = core_out;
  assign pad_oe  = core_oe;

endmodule

// File: rtl/fio_bus_map.sv
module fio_bus_map #(
  parameter int INT_W  = 114,
  parameter int REQ_W  = 71,
  parameter int RSP_W  = 33,
  parameter int GAP_LO = 92,
  parameter int GAP_N  = 10
) (
  input  logic [REQ_W-1:0] req_vec,
  input  logic [INT_W-1:0] core_out,
  output logic [INT_W-1:0] core_in_bus,
  output logic [RSP_W-1:0] rsp_vec
);

  for (genvar i = 0; i < INT_W; i++) begin : g_pos
    localparam bool_gap = (i >= GAP_LO) && (i < GAP_LO + GAP_N);
    localparam int SLOT = (i < GAP_LO) ? i : i - GAP_N;
    if (bool_gap) begin : g_gap
      assign core_in_bus[i] = 1'b0;
    end else if (SLOT < REQ_W) begin : g_req
      assign core_in_bus[i] = req_vec[SLOT];
    end else begin : g_rsp
      assign core_in_bus[i] = 1'b0;
      assign rsp_vec[SLOT-REQ_W] = core_out[i];
    end
  end

endmodule

// File: rtl/fio_int_route.sv
module fio_int_route
  import fio_pkg::*;
#(
  parameter int INT_W = 114,
  parameter int LA_W  = 128,
  parameter int RSP_W = 33,
  parameter int GAP_LO = 92,
  parameter int GAP_N  = 10,
  localparam int MON_W = LA_W - INT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  io_mode_e         mode,
  input  logic [INT_W-1:0] la_in,
  input  logic [INT_W-1:0] core_out,
  input  logic [MON_W-1:0] mon,
  input  logic [INT_W-1:0] core_in_bus,
  input  logic [RSP_W-1:0] rsp_vec,
  output logic [INT_W-1:0] core_in,
  output logic [LA_W-1:0]  la_out,
  output logic [RSP_W-1:0] rsp_out
);

  always_comb begin
    core_in = la_in;
    la_out  = {mon, core_out};
    rsp_out = '0;
    if (mode == MODE_BUS) begin
      core_in = core_in_bus;
      la_out  = '0;
      rsp_out = rsp_vec;
    end
  end

  // R8: analyzer port stays silent in bus mode
  a_r8_probe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BUS) |-> (la_out == '0));

  // R8: bus response stays silent in probe mode
  a_r8_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PROBE) |-> (rsp_out == '0));

  // R4: spare analyzer bits carry the monitor points in probe mode
  a_r4_monitor_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PROBE) |-> (la_out[LA_W-1:INT_W] == mon));

  // R7: unconnected block receives zeros in bus mode
  a_r7_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BUS) |-> (core_in[GAP_LO +: GAP_N] == '0));

  // R3: probe mode hands the host bits to the fabric
  a_r3_probe_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PROBE) |-> (core_in == la_in));

endmodule

// File: rtl/fabric_io_switch.sv
module fabric_io_switch
  import fio_pkg::*;
#(
  parameter int EXT_W  = EXT_W_D,
  parameter int INT_W  = INT_W_D,
  parameter int LA_W   = LA_W_D,
  parameter int ADDR_W = ADDR_W_D,
  parameter int DATA_W = DATA_W_D,
  parameter int SEL_W  = SEL_W_D,
  parameter int GAP_LO = GAP_LO_D,
  parameter int GAP_N  = GAP_N_D,
  localparam int MON_W = LA_W - INT_W,
  localparam int REQ_W = 3 + SEL_W + ADDR_W + DATA_W,
  localparam int RSP_W = 1 + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic [EXT_W-1:0]  ext_pad_in,
  output logic [EXT_W-1:0]  ext_pad_out,
  output logic [EXT_W-1:0]  ext_pad_oe,
  output logic [EXT_W-1:0]  fab_ext_in,
  input  logic [EXT_W-1:0]  fab_ext_out,
  input  logic [EXT_W-1:0]  fab_ext_oe,
  output logic [INT_W-1:0]  fab_int_in,
  input  logic [INT_W-1:0]  fab_int_out,
  input  logic [MON_W-1:0]  fab_mon,
  input  logic [INT_W-1:0]  la_in,
  output logic [LA_W-1:0]   la_out,
  input  logic              bus_cyc,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic [ADDR_W-1:0] bus_adr,
  input  logic [DATA_W-1:0] bus_wdat,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdat
);

  io_mode_e          mode;
  logic [REQ_W-1:0]  req_vec;
  logic [RSP_W-1:0]  rsp_vec;
  logic [RSP_W-1:0]  rsp_out;
  logic [INT_W-1:0]  core_in_bus;

  assign req_vec = {bus_wdat, bus_adr, bus_sel, bus_we, bus_stb, bus_cyc};
  assign {bus_rdat, bus_ack} = rsp_out;

  fio_mode_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_async (mode_sel),
    .mode       (mode)
  );

  fio_ext_pass #(.EXT_W(EXT_W)) u_ext (
    .pad_in   (ext_pad_in),
    .pad_out  (ext_pad_out),
    .pad_oe   (ext_pad_oe),
    .core_in  (fab_ext_in),
    .core_out (fab_ext_out),
    .core_oe  (fab_ext_oe)
  );

  fio_bus_map #(
    .INT_W(INT_W), .REQ_W(REQ_W), .RSP_W(RSP_W),
    .GAP_LO(GAP_LO), .GAP_N(GAP_N)
  ) u_map (
    .req_vec     (req_vec),
    .core_out    (fab_int_out),
    .core_in_bus (core_in_bus),
    .rsp_vec     (rsp_vec)
  );

  fio_int_route #(
    .INT_W(INT_W), .LA_W(LA_W), .RSP_W(RSP_W),
    .GAP_LO(GAP_LO), .GAP_N(GAP_N)
  ) u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .la_in       (la_in),
    .core_out    (fab_int_out),
    .mon         (fab_mon),
    .core_in_bus (core_in_bus),
    .rsp_vec     (rsp_vec),
    .core_in     (fab_int_in),
    .la_out      (la_out),
    .rsp_out     (rsp_out)
  );

  // R1: pad inputs reach the fabric unchanged at every edge
  a_r1_ext_through: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_ext_in == ext_pad_in) && (ext_pad_oe == fab_ext_oe));

endmodule

// File: tb/fabric_io_switch_tb_top.sv
module fabric_io_switch_tb_top;

  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_sel = 1'b0;
  logic [29:0]  ext_pad_in = '0, fab_ext_out = '0, fab_ext_oe = '0;
  logic [29:0]  ext_pad_out, ext_pad_oe, fab_ext_in;
  logic [113:0] fab_int_out = '0, la_in = '0;
  logic [113:0] fab_int_in;
  logic [13:0]  fab_mon = '0;
  logic [127:0] la_out;
  logic         bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
  logic [3:0]   bus_sel = '0;
  logic [31:0]  bus_adr = '0, bus_wdat = '0;
  logic         bus_ack;
  logic [31:0]  bus_rdat;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    string        req;
    logic [113:0] fin;
    logic [127:0] lout;
    logic         ack;
    logic [31:0]  rdat;
    logic [29:0]  fext;
    logic [29:0]  pout;
    logic [29:0]  poe;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;

  always #(CLK_P/2) clk = ~clk;

  fabric_io_switch dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .ext_pad_in(ext_pad_in), .ext_pad_out(ext_pad_out), .ext_pad_oe(ext_pad_oe),
    .fab_ext_in(fab_ext_in), .fab_ext_out(fab_ext_out), .fab_ext_oe(fab_ext_oe),
    .fab_int_in(fab_int_in), .fab_int_out(fab_int_out), .fab_mon(fab_mon),
    .la_in(la_in), .la_out(la_out),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_ack(bus_ack), .bus_rdat(bus_rdat)
  );

  // Expected outputs built from the requirement text
  function automatic exp_t model(bit bus_mode, string req);
    exp_t e;
    e.req  = req;
    e.fext = ext_pad_in;
    e.pout = fab_ext_out;
    e.poe  = fab_ext_oe;
    if (!bus_mode) begin
      e.fin  = la_in;
      e.lout = {fab_mon, fab_int_out};
      e.ack  = 1'b0;
      e.rdat = '0;
    end else begin
      e.lout = '0;
      e.fin  = '0;
      e.fin[0] = bus_cyc;
      e.fin[1] = bus_stb;
      e.fin[2] = bus_we;
      for (int k = 0; k < 4; k++)  e.fin[3+k]  = bus_sel[k];
      for (int k = 0; k < 32; k++) e.fin[7+k]  = bus_adr[k];
      for (int k = 0; k < 32; k++) e.fin[39+k] = bus_wdat[k];
      e.ack = fab_int_out[71];
      for (int k = 0; k < 32; k++)
        e.rdat[k] = (k < 20) ? fab_int_out[72+k] : fab_int_out[82+k];
    end
    return e;
  endfunction

  task automatic check_now(bit bus_mode, string req);
    exp_q.push_back(model(bus_mode, req));
    ->chk_ev;
    #2;
  endtask

  task automatic scramble();
    ext_pad_in  = 30'($urandom);
    fab_ext_out = 30'($urandom);
    fab_ext_oe  = 30'($urandom);
    fab_mon     = 14'($urandom);
    for (int k = 0; k < 114; k++) begin
      la_in[k]       = 1'($urandom_range(0, 1));
      fab_int_out[k] = 1'($urandom_range(0, 1));
    end
    bus_cyc  = 1'($urandom_range(0, 1));
    bus_stb  = 1'($urandom_range(0, 1));
    bus_we   = 1'($urandom_range(0, 1));
    bus_sel  = 4'($urandom);
    bus_adr  = $urandom;
    bus_wdat = $urandom;
  endtask

  task automatic cmp(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.req, "fab_int_in", {14'd0, fab_int_in}, {14'd0, e.fin});
        cmp(e.req, "la_out", la_out, e.lout);
        cmp(e.req, "bus_ack/rdat", {95'd0, bus_ack, bus_rdat}, {95'd0, e.ack, e.rdat});
        cmp("R1", "ext", {38'd0, fab_ext_in, ext_pad_out, ext_pad_oe},
            {38'd0, e.fext, e.pout, e.poe});
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic        ack_keep;
    logic [31:0] rdat_keep;
    // R9: reset forces probe mode although the pin asks for bus
    mode_sel = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    scramble();
    check_now(1'b0, "R9");
    mode_sel = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R3 R4: probe mode under several patterns
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      scramble();
      check_now(1'b0, "R3");
    end
    @(negedge clk);
    la_in = '1; fab_int_out = '0; fab_mon = '1;
    check_now(1'b0, "R4");
    // R8: bus response silent in probe mode even with bus traffic
    bus_stb = 1'b1; fab_int_out = '1;
    check_now(1'b0, "R8");

    // R2: switch to bus mode, two-edge lag
    @(negedge clk);
    scramble();
    mode_sel = 1'b1;
    check_now(1'b0, "R2");
    @(negedge clk);
    check_now(1'b0, "R2");
    @(negedge clk);
    check_now(1'b1, "R2");

    // R5 R6: bus mode under several patterns
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      scramble();
      check_now(1'b1, "R5");
    end
    @(negedge clk);
    bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = 1'b1;
    bus_sel = '1; bus_adr = '1; bus_wdat = '1; la_in = '1;
    fab_int_out = '0;
    check_now(1'b1, "R8");
    fab_int_out = '1;
    bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
    bus_sel = '0; bus_adr = '0; bus_wdat = '0;
    check_now(1'b1, "R6");

    // R7: toggling only the unconnected block leaves the bus response alone
    @(negedge clk);
    scramble();
    fab_int_out[101:92] = '0;
    #1;
    ack_keep  = bus_ack;
    rdat_keep = bus_rdat;
    fab_int_out[101:92] = '1;
    check_now(1'b1, "R7");
    cmp("R7", "ack held", {127'd0, bus_ack}, {127'd0, ack_keep});
    cmp("R7", "rdat held", {96'd0, bus_rdat}, {96'd0, rdat_keep});

    // R2: back to probe mode
    @(negedge clk);
    mode_sel = 1'b0;
    check_now(1'b1, "R2");
    @(negedge clk);
    check_now(1'b1, "R2");
    @(negedge clk);
    check_now(1'b0, "R2");

    // R9: reset in bus mode returns to probe at once, lag after release
    @(negedge clk);
    mode_sel = 1'b1;
    repeat (3) @(negedge clk);
    check_now(1'b1, "R9");
    rst_n = 1'b0;
    #1;
    check_now(1'b0, "R9");
    @(negedge clk);
    check_now(1'b0, "R9");
    rst_n = 1'b1;
    @(negedge clk);
    check_now(1'b0, "R9");
    @(negedge clk);
    check_now(1'b1, "R9");

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule